// File: doc/BRIEF.md
# DRAM-to-SRAM Bridge Adapter

This block lets a memory controller built for a multiplexed-address, one-bit-wide DRAM work unchanged with a byte-wide asynchronous SRAM. A configuration bit selects the path. When the bit is clear, every controller signal passes straight to the DRAM pins and the DRAM read bit passes straight back. When the bit is set, the DRAM pins are held idle. The bridge then captures the row address on the falling row strobe and the column address on the falling column strobe, and joins them into one flat SRAM address with the row in the upper half.

A write moves a word of `DW` bits over the serial line, most significant bit first, one bit per clock. The bridge collects the bits into a parallel word and then pulses the SRAM write strobe for a fixed number of cycles. A read drives the SRAM output enable for `ACC` cycles, so a slow part with about 100 ns access time fits at the default setting. The bridge then captures the word and shifts it back out one bit per clock. The controller sees the same fixed latencies in both modes, so the bridge gives no speed gain and needs no change to the controller.

Top module: `dram_sram_bridge`

## Requirements
- R1: With `cfg_sram_mode` low, `d_ras_n`, `d_cas_n`, `d_we_n`, `d_addr` and `d_wbit` equal the matching controller inputs in the same cycle. `c_rbit` equals `d_rbit`. `s_ce_n`, `s_oe_n` and `s_we_n` stay high.
- R2: With `cfg_sram_mode` high, `d_ras_n`, `d_cas_n` and `d_we_n` are held high and `d_addr` and `d_wbit` are held at zero.
- R3: The row address is taken from `c_addr` at the first clock edge where `c_ras_n` is seen low after being high. The column address is taken at the matching column strobe edge (E0). `s_addr` is {row, column}, with the row in the upper `AW` bits.
- R4: On a write (`c_we_n` low at E0), `c_wbit` is sampled at edges E0 through E(DW-1), most significant bit first, and the collected word appears on `s_wdata`.
- R5: After edge E(DW-1), `s_we_n` is low for exactly `WE` cycles, together with `s_ce_n`. `s_addr` and `s_wdata` stay stable while it is low.
- R6: On a read (`c_we_n` high at E0), `s_oe_n` and `s_ce_n` are low from E0 to E(ACC). The SRAM word is captured at E(ACC), after which `s_oe_n` is high.
- R7: Read bit i (0 = most significant) is on `c_rbit` between edges E(ACC+i) and E(ACC+i+1), so a read returns the word last written to that address.
- R8: After reset in SRAM mode, all SRAM strobes are high and `c_rbit` and `s_addr` are zero.
- R9: `s_we_n` and `s_oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sram_mode | input | 1 | 1 = SRAM bridge path, 0 = DRAM pass-through |
| c_ras_n | input | 1 | Controller row strobe, active low |
| c_cas_n | input | 1 | Controller column strobe, active low |
| c_we_n | input | 1 | Controller write enable, active low |
| c_addr | input | AW | Controller multiplexed address |
| c_wbit | input | 1 | Controller serial write data |
| c_rbit | output | 1 | Serial read data to controller |
| d_ras_n | output | 1 | DRAM row strobe |
| d_cas_n | output | 1 | DRAM column strobe |
| d_we_n | output | 1 | DRAM write enable |
| d_addr | output | AW | DRAM multiplexed address |
| d_wbit | output | 1 | DRAM serial write data |
| d_rbit | input | 1 | DRAM serial read data |
| s_addr | output | 2*AW | SRAM flat address |
| s_ce_n | output | 1 | SRAM chip enable |
| s_oe_n | output | 1 | SRAM output enable |
| s_we_n | output | 1 | SRAM write strobe |
| s_wdata | output | DW | SRAM write data |
| s_rdata | input | DW | SRAM read data |

## Verification
If the access sequencer is in the wrong state, the SRAM strobes show it within one cycle of the column strobe. The write strobe pulse would also come early, come late, or have the wrong length. A bit count that is off by one moves every bit of the word. It therefore shows up as a read-back mismatch on the very next read of that address, and the sweep over every address exposes it at once. A wrong row or column latch sends the data to another location. That is seen when the address is checked during the strobe, or at the latest when the location is read back.

// File: rtl/bridge_pkg.sv
// Shared types for the DRAM-to-SRAM bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package bridge_pkg;

    // Access sequencer states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for a column strobe
        ST_WCOL = 3'd1,   // collecting serial write bits
        ST_WSTB = 3'd2,   // SRAM write strobe active
        ST_RFET = 3'd3,   // SRAM output enabled, waiting for access time
        ST_RSHF = 3'd4    // shifting the read word out
    } brg_state_t;

endpackage

// File: rtl/brg_strobe_capture.sv
// Detects the falling row and column strobes and latches the row and column
// halves of the multiplexed address.
// Assumes: controller inputs are synchronous to clk; strobes are only
// honoured while the bridge is enabled and the sequencer is idle.
module brg_strobe_capture #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          idle,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] row_q,
    output logic [AW-1:0] col_q,
    output logic          cas_fall
);
    logic ras_prev;
    logic cas_prev;
    logic ras_fall;

    // Remember the previous strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_prev <= 1'b1;
            cas_prev <= 1'b1;
        end else begin
            ras_prev <= ras_n;
            cas_prev <= cas_n;
        end
    end

    // Qualified falling-edge pulses
    always_comb begin
        ras_fall = en && idle && ras_prev && !ras_n;
        cas_fall = en && idle && cas_prev && !cas_n;
    end

    // Latch row and column halves on their strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (ras_fall) row_q <= addr;
            if (cas_fall) col_q <= addr;
        end
    end
endmodule

// File: rtl/brg_seq.sv
// Access sequencer: after a column strobe it either counts the serial write
// bits in and pulses the SRAM write strobe, or holds the output enable for
// the access time and then runs the read shifter.
// Assumes: DW >= 2, ACC >= 1, WE >= 1; a column strobe arriving while busy
// is ignored.
module brg_seq
    import bridge_pkg::*;
#(
    parameter int DW  = 8,
    parameter int ACC = 5,
    parameter int WE  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cas_fall,
    input  logic wr_req,
    output logic idle,
    output logic wr_shift,
    output logic rd_load,
    output logic rd_shift,
    output logic seq_ce_n,
    output logic seq_oe_n,
    output logic seq_we_n
);
    localparam int CMAX0 = (DW > ACC) ? DW : ACC;
    localparam int CMAX  = (CMAX0 > WE) ? CMAX0 : WE;
    localparam int CW    = $clog2(CMAX + 1);

    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);
    localparam logic [CW-1:0] LAST_ACC = CW'(ACC);
    localparam logic [CW-1:0] LAST_WE  = CW'(WE - 1);

    brg_state_t    state;
    logic [CW-1:0] cnt;

    // State and cycle counter advance
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cas_fall) begin
                        state <= wr_req ? ST_WCOL : ST_RFET;
                        cnt   <= CW'(1);
                    end
                end
                ST_WCOL: begin
                    if (cnt == LAST_BIT) begin
                        state <= ST_WSTB;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WSTB: begin
                    if (cnt == LAST_WE) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RFET: begin
                    if (cnt == LAST_ACC) begin
                        state <= ST_RSHF;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RSHF: begin
                    if (cnt == LAST_BIT) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Datapath controls and SRAM strobes decoded from the state
    always_comb begin
        idle     = (state == ST_IDLE);
        wr_shift = (idle && cas_fall && wr_req) || (state == ST_WCOL);
        rd_load  = (state == ST_RFET) && (cnt == LAST_ACC);
        rd_shift = (state == ST_RSHF) && (cnt != LAST_BIT);
        seq_we_n = !(state == ST_WSTB);
        seq_oe_n = !(state == ST_RFET);
        seq_ce_n = !((state == ST_WSTB) || (state == ST_RFET));
    end
endmodule

// File: rtl/brg_deser.sv
// Serial-in, parallel-out register that collects write bits MSB first.
// Assumes: DW >= 2.
module brg_deser #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift,
    input  logic          bit_in,
    output logic [DW-1:0] word
);
    // Shift a new bit in at the low end
    always_ff @(posedge clk) begin
        if (!rst_n) word <= '0;
        else if (shift) word <= {word[DW-2:0], bit_in};
    end
endmodule

// File: rtl/brg_ser.sv
// Parallel-in, serial-out register that returns a read word MSB first.
// Assumes: DW >= 2; load has priority over shift.
module brg_ser #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic [DW-1:0] word,
    output logic          bit_out
);
    logic [DW-1:0] sh;

    // Load the fetched word, then move it out towards the top bit
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else if (load) sh <= word;
        else if (shift) sh <= {sh[DW-2:0], 1'b0};
    end

    assign bit_out = sh[DW-1];
endmodule

// File: rtl/dram_sram_bridge.sv
// Top of the bridge. Selects between direct DRAM pass-through and the SRAM
// path that demultiplexes the address and converts between serial and
// parallel data.
// Assumes: cfg_sram_mode changes only while no access is in progress;
// ACC cycles of the clock cover the SRAM access time.
module dram_sram_bridge #(
    parameter int AW  = 12,
    parameter int DW  = 8,
    parameter int ACC = 5,
    parameter int WE  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_sram_mode,
    input  logic            c_ras_n,
    input  logic            c_cas_n,
    input  logic            c_we_n,
    input  logic [AW-1:0]   c_addr,
    input  logic            c_wbit,
    output logic            c_rbit,
    output logic            d_ras_n,
    output logic            d_cas_n,
    output logic            d_we_n,
    output logic [AW-1:0]   d_addr,
    output logic            d_wbit,
    input  logic            d_rbit,
    output logic [2*AW-1:0] s_addr,
    output logic            s_ce_n,
    output logic            s_oe_n,
    output logic            s_we_n,
    output logic [DW-1:0]   s_wdata,
    input  logic [DW-1:0]   s_rdata
);
    logic [AW-1:0] row_q;
    logic [AW-1:0] col_q;
    logic          cas_fall;
    logic          idle;
    logic          wr_shift;
    logic          rd_load;
    logic          rd_shift;
    logic          seq_ce_n;
    logic          seq_oe_n;
    logic          seq_we_n;
    logic          ser_bit;

    brg_strobe_capture #(.AW(AW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_sram_mode),
        .idle     (idle),
        .ras_n    (c_ras_n),
        .cas_n    (c_cas_n),
        .addr     (c_addr),
        .row_q    (row_q),
        .col_q    (col_q),
        .cas_fall (cas_fall)
    );

    brg_seq #(.DW(DW), .ACC(ACC), .WE(WE)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_sram_mode),
        .cas_fall (cas_fall),
        .wr_req   (!c_we_n),
        .idle     (idle),
        .wr_shift (wr_shift),
        .rd_load  (rd_load),
        .rd_shift (rd_shift),
        .seq_ce_n (seq_ce_n),
        .seq_oe_n (seq_oe_n),
        .seq_we_n (seq_we_n)
    );

    brg_deser #(.DW(DW)) u_deser (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  (wr_shift),
        .bit_in (c_wbit),
        .word   (s_wdata)
    );

    brg_ser #(.DW(DW)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rd_load),
        .shift   (rd_shift),
        .word    (s_rdata),
        .bit_out (ser_bit)
    );

    // Flat SRAM address: row in the upper half
    assign s_addr = {row_q, col_q};

    // Mode steering between the DRAM pins and the SRAM path
    always_comb begin
        if (cfg_sram_mode) begin
            d_ras_n = 1'b1;
            d_cas_n = 1'b1;
            d_we_n  = 1'b1;
            d_addr  = '0;
            d_wbit  = 1'b0;
            c_rbit  = ser_bit;
            s_ce_n  = seq_ce_n;
            s_oe_n  = seq_oe_n;
            s_we_n  = seq_we_n;
        end else begin
            d_ras_n = c_ras_n;
            d_cas_n = c_cas_n;
            d_we_n  = c_we_n;
            d_addr  = c_addr;
            d_wbit  = c_wbit;
            c_rbit  = d_rbit;
            s_ce_n  = 1'b1;
            s_oe_n  = 1'b1;
            s_we_n  = 1'b1;
        end
    end
endmodule

// File: rtl/dram_sram_bridge_chk.sv
// Checker for the bridge, attached with bind. Relates the SRAM strobes to
// the controller strobes and to the SRAM address and data.
// Assumes: same parameters as the bound instance.
module dram_sram_bridge_chk #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_sram_mode,
    input logic            c_cas_n,
    input logic            c_we_n,
    input logic [2*AW-1:0] s_addr,
    input logic            s_oe_n,
    input logic            s_we_n,
    input logic [DW-1:0]   s_wdata
);
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_we_n || s_oe_n));

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_we_n && !$past(s_we_n)) |-> ($stable(s_addr) && $stable(s_wdata)));

    // R5
    wr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_we_n) |-> (!$past(c_cas_n) && !$past(c_we_n) && $past(cfg_sram_mode)));

    // R6
    rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_oe_n) |-> (!$past(c_cas_n) && $past(c_we_n) && $past(cfg_sram_mode)));

    // R6
    rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_oe_n && !$past(s_oe_n)) |-> $stable(s_addr));
endmodule

bind dram_sram_bridge dram_sram_bridge_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_sram_mode (cfg_sram_mode),
    .c_cas_n       (c_cas_n),
    .c_we_n        (c_we_n),
    .s_addr        (s_addr),
    .s_oe_n        (s_oe_n),
    .s_we_n        (s_we_n),
    .s_wdata       (s_wdata)
);

// File: tb/dram_sram_bridge_tb.sv
// Bench: sweeps every address of a small configuration with write then
// read-back against a reference array, and checks DRAM pass-through.
module dram_sram_bridge_tb;
    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int ACC = 3;
    localparam int WE  = 2;
    localparam int NLOC = 1 << (2 * AW);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_sram_mode = 1'b1;
    logic            c_ras_n = 1'b1;
    logic            c_cas_n = 1'b1;
    logic            c_we_n = 1'b1;
    logic [AW-1:0]   c_addr = '0;
    logic            c_wbit = 1'b0;
    logic            c_rbit;
    logic            d_ras_n, d_cas_n, d_we_n, d_wbit;
    logic [AW-1:0]   d_addr;
    logic            d_rbit = 1'b0;
    logic [2*AW-1:0] s_addr;
    logic            s_ce_n, s_oe_n, s_we_n;
    logic [DW-1:0]   s_wdata;
    logic [DW-1:0]   s_rdata;

    logic [DW-1:0]   sram_mem [NLOC];
    logic [DW-1:0]   ref_mem  [NLOC];
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dram_sram_bridge #(.AW(AW), .DW(DW), .ACC(ACC), .WE(WE)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_sram_mode(cfg_sram_mode),
        .c_ras_n(c_ras_n), .c_cas_n(c_cas_n), .c_we_n(c_we_n),
        .c_addr(c_addr), .c_wbit(c_wbit), .c_rbit(c_rbit),
        .d_ras_n(d_ras_n), .d_cas_n(d_cas_n), .d_we_n(d_we_n),
        .d_addr(d_addr), .d_wbit(d_wbit), .d_rbit(d_rbit),
        .s_addr(s_addr), .s_ce_n(s_ce_n), .s_oe_n(s_oe_n),
        .s_we_n(s_we_n), .s_wdata(s_wdata), .s_rdata(s_rdata)
    );

    // SRAM stub: stores on the write strobe, drives data while enabled
    always_ff @(posedge clk) begin
        if (!s_we_n && !s_ce_n) sram_mem[s_addr] <= s_wdata;
    end
    assign s_rdata = (!s_oe_n && !s_ce_n) ? sram_mem[s_addr] : '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int pass);
        logic [DW-1:0] v;
        v = DW'((a * 37 + 11 + pass * 101) & ((1 << DW) - 1));
        return v;
    endfunction

    task automatic do_write(input logic [2*AW-1:0] a, input logic [DW-1:0] d,
                            input bit verbose);
        @(negedge clk);
        c_ras_n = 1'b0; c_addr = a[2*AW-1:AW];
        @(negedge clk);
        c_cas_n = 1'b0; c_we_n = 1'b0; c_addr = a[AW-1:0]; c_wbit = d[DW-1];
        for (int i = 1; i < DW; i++) begin
            @(negedge clk);
            c_wbit = d[DW-1-i];
        end
        for (int k = 0; k < WE; k++) begin
            @(negedge clk);
            if (verbose || k == 0) begin
                chk(!s_we_n && !s_ce_n, "R5 strobe low", {31'd0, s_we_n}, 0);
                chk(s_wdata == d, "R4 word", 32'(s_wdata), 32'(d));
                chk(s_addr == a, "R3 write address", 32'(s_addr), 32'(a));
            end
        end
        @(negedge clk);
        if (verbose) chk(s_we_n && s_ce_n, "R5 strobe ends", {31'd0, s_we_n}, 1);
        c_cas_n = 1'b1; c_ras_n = 1'b1; c_we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [2*AW-1:0] a, input logic [DW-1:0] e,
                           input bit verbose);
        logic [DW-1:0] got;
        @(negedge clk);
        c_ras_n = 1'b0; c_addr = a[2*AW-1:AW];
        @(negedge clk);
        c_cas_n = 1'b0; c_we_n = 1'b1; c_addr = a[AW-1:0];
        for (int n = 1; n <= ACC; n++) begin
            @(negedge clk);
            if (verbose || n == 1) begin
                chk(!s_oe_n && !s_ce_n, "R6 output enable", {31'd0, s_oe_n}, 0);
                chk(s_addr == a, "R3 read address", 32'(s_addr), 32'(a));
                chk(d_ras_n && d_cas_n && d_we_n, "R2 DRAM idle",
                    {29'd0, d_ras_n, d_cas_n, d_we_n}, 7);
            end
        end
        got = '0;
        for (int i = 0; i < DW; i++) begin
            @(negedge clk);
            if (i == 0 && verbose)
                chk(s_oe_n, "R6 enable released", {31'd0, s_oe_n}, 1);
            got = {got[DW-2:0], c_rbit};
        end
        chk(got == e, "R7 read-back", 32'(got), 32'(e));
        @(negedge clk);
        c_cas_n = 1'b1; c_ras_n = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(s_ce_n && s_oe_n && s_we_n, "R8 strobes", {29'd0, s_ce_n, s_oe_n, s_we_n}, 7);
        chk(c_rbit == 1'b0, "R8 read bit", {31'd0, c_rbit}, 0);
        chk(s_addr == '0, "R8 address", 32'(s_addr), 0);

        // Pass 0: write every location, then read back in strided order
        for (int a = 0; a < NLOC; a++) begin
            do_write((2*AW)'(a), pat(a, 0), a < 4);
            ref_mem[a] = pat(a, 0);
        end
        for (int j = 0; j < NLOC; j++) begin
            int a;
            a = (j * 7 + 3) % NLOC;
            do_read((2*AW)'(a), ref_mem[a], j < 4);
        end

        // Pass 1: overwrite half with a new pattern, read all back
        for (int a = 0; a < NLOC; a += 2) begin
            do_write((2*AW)'(a), ~pat(a, 1), 1'b0);
            ref_mem[a] = ~pat(a, 1);
        end
        for (int a = NLOC - 1; a >= 0; a--) do_read((2*AW)'(a), ref_mem[a], 1'b0);

        // R1 DRAM pass-through
        @(negedge clk);
        cfg_sram_mode = 1'b0;
        for (int j = 0; j < 64; j++) begin
            logic [7:0] v;
            v = 8'(j * 29 + 5);
            c_ras_n = v[0]; c_cas_n = v[1]; c_we_n = v[2]; c_wbit = v[3];
            d_rbit = v[4]; c_addr = AW'(v >> 2);
            #1;
            chk(d_ras_n == c_ras_n && d_cas_n == c_cas_n && d_we_n == c_we_n,
                "R1 strobes", {29'd0, d_ras_n, d_cas_n, d_we_n},
                {29'd0, c_ras_n, c_cas_n, c_we_n});
            chk(d_addr == c_addr && d_wbit == c_wbit, "R1 addr/data",
                32'({d_addr, d_wbit}), 32'({c_addr, c_wbit}));
            chk(c_rbit == d_rbit, "R1 read bit", {31'd0, c_rbit}, {31'd0, d_rbit});
            chk(s_ce_n && s_oe_n && s_we_n, "R1 SRAM quiet",
                {29'd0, s_ce_n, s_oe_n, s_we_n}, 7);
            @(negedge clk);
        end
        c_ras_n = 1'b1; c_cas_n = 1'b1; c_we_n = 1'b1; d_rbit = 1'b0;
        @(negedge clk);
        @(negedge clk);
        cfg_sram_mode = 1'b1;
        @(negedge clk);

        // Back in SRAM mode: contents untouched by DRAM-mode traffic
        for (int a = 0; a < 16; a++) do_read((2*AW)'(a * 13), ref_mem[a * 13], 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule